// File: doc/BRIEF.md
# Bandwidth Slot-Table Fill Engine

This engine builds the ownership table that a time-slotted memory arbiter consults: 64 slots, each naming one of 14 clients. A run starts on a one-cycle start pulse and works from a snapshot of three inputs: a requested slot count for each client, an active mask and a budget of unused slots. The block does not convert bandwidth to slots; it takes slot counts as given.

The first pass visits clients from the lowest index up. A client with a non-zero request is placed with a stride of 64 divided by its request. Its cursor starts at slot 0, steps by one over owned slots and by the stride after each placement, and stops at 64. An active client with no request gets a single slot with the same sliding cursor, but only while the budget is non-zero, and each such grant uses up one unit of the budget. The second pass walks the slots in order. Each slot still unowned goes to the first active client found at or after a rotating pointer, and the pointer then moves to the client after the one chosen.

The second pass also streams out the table, one slot index and owner per cycle, with slot 0 first. A one-cycle done pulse follows the last write.

Top module: `slotfill_engine`

## Requirements
- R1: After reset, busy_o, wr_valid_o and done_o are all low.
- R2: A start pulse while idle begins a run, and busy_o is high in the following cycle. A start pulse while a run is in progress has no effect: the run keeps the inputs it sampled, and no second run follows it.
- R3: Pass one places clients in ascending index order. A client with request r (1 to 64) uses stride 64/r (integer division). Its cursor starts at slot 0, moves by 1 past an owned slot and by the stride after taking a free one, and stops once it reaches 64. An owned slot is never reassigned.
- R4: A request above 64 is treated as 64, so the stride is 1.
- R5: In pass one, an active client with a zero request takes exactly one slot (the first free slot from 0) if the remaining budget is non-zero. Each grant lowers the budget by one. With budget 0, no such client gets a pass-one slot.
- R6: A client that is inactive and has a zero request owns no slot in the finished table.
- R7: In pass two, each unowned slot, in slot order, goes to the first active client at or after a pointer that starts at 0 for each run. The pointer then becomes (chosen client + 1) mod 14.
- R8: If no client is active, an unowned slot takes the pointer value itself. With no requests and no active clients, slot s therefore holds s mod 14.
- R9: Each run emits exactly 64 writes on consecutive cycles, with wr_idx_o running from 0 to 63. Every wr_val_o lies in 0 to 13. Inside the block, an unowned slot holds the value 15, which is never emitted.
- R10: done_o is high for exactly one cycle, the cycle after the write of slot 63, and busy_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; acted on only when idle |
| req_cnt_i | input | 112 | Requested slot counts, 8 bits per client, client c at bits [8c+7:8c] |
| active_i | input | 14 | Active flag per client, bit c for client c |
| budget_i | input | 7 | Number of unused slots available for zero-request grants |
| busy_o | output | 1 | High while a run is in progress |
| wr_valid_o | output | 1 | A slot write is presented this cycle |
| wr_idx_o | output | 6 | Slot index of the write |
| wr_val_o | output | 4 | Client owning that slot |
| done_o | output | 1 | One-cycle pulse after the last write |

## Verification
The bench compares each emitted table against a model it computes itself. It also checks selected slots by value. An empty configuration tells the modulo fallback apart from round-robin among active clients. Two clients with equal strides show ascending order and sliding past owned slots, and an uneven stride tests the case where the cursor lands exactly on slot 63. Pairs of runs that differ only in budget separate the zero-request grant from the pass-two fill. A masked-out idle client and an oversized request test the skip and the clamp. A second start pulse sent mid-run with different inputs must leave the table unchanged.

// File: rtl/slotfill_pkg.sv
package slotfill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_P1,
    ST_P2,
    ST_FIN
  } sf_state_e;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_PICK,
    PH_WALK
  } place_ph_e;

  // Stride for a request: zero-request grants use a full-table stride,
  // oversize requests clamp to one slot apart.
  function automatic int unsigned stride_for(int unsigned req, int unsigned slots);
    if (req == 0) return slots;
    if (req >= slots) return 1;
    return slots / req;
  endfunction

  // Increment modulo m.
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned m);
    return (v + 1 >= m) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/sf_slot_table.sv
module sf_slot_table #(
  parameter int SLOTS = 64,
  parameter int CW    = 4,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [CW-1:0] rdata_o,
  output logic          occupied_o
);

  localparam logic [CW-1:0] EMPTY = '1;

  logic [CW-1:0]    ent_q [SLOTS];
  logic [SLOTS-1:0] occ_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) ent_q[i] <= EMPTY;
    end else if (clear_i) begin
      for (int i = 0; i < SLOTS; i++) ent_q[i] <= EMPTY;
    end else if (we_i) begin
      ent_q[waddr_i] <= wdata_i;
    end
  end

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_occ
      assign occ_w[g] = (ent_q[g] != EMPTY);
    end
  endgenerate

  assign rdata_o    = ent_q[raddr_i];
  assign occupied_o = occ_w[raddr_i];

  // R3: the placement walk only ever writes a slot that is still free
  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> !occ_w[waddr_i]);

endmodule

// File: rtl/sf_rr_pick.sv
module sf_rr_pick #(
  parameter int CLIENTS = 14,
  parameter int CW      = 4
) (
  input  logic [CLIENTS-1:0] active_i,
  input  logic [CW-1:0]      ptr_i,
  output logic [CW-1:0]      pick_o,
  output logic               found_o
);

  // Scan downward so that the closest active client at or after the
  // pointer is the last assignment and wins.
  always_comb begin
    pick_o  = ptr_i;
    found_o = 1'b0;
    for (int k = CLIENTS - 1; k >= 0; k--) begin
      int idx;
      idx = int'(ptr_i) + k;
      if (idx >= CLIENTS) idx = idx - CLIENTS;
      if (active_i[idx]) begin
        pick_o  = CW'(idx);
        found_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sf_place_seq.sv
module sf_place_seq
  import slotfill_pkg::*;
#(
  parameter int SLOTS   = 64,
  parameter int CLIENTS = 14,
  parameter int REQ_W   = 8,
  parameter int CW      = 4,
  parameter int BW      = 7,
  localparam int IW     = $clog2(SLOTS),
  localparam int PW     = IW + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     kick_i,
  input  logic [CLIENTS*REQ_W-1:0] req_i,
  input  logic [CLIENTS-1:0]       active_i,
  input  logic [BW-1:0]            budget_i,
  input  logic                     occupied_i,
  output logic [IW-1:0]            raddr_o,
  output logic                     we_o,
  output logic [IW-1:0]            waddr_o,
  output logic [CW-1:0]            wdata_o,
  output logic                     finish_o
);

  localparam logic [PW-1:0] END_POS  = PW'(SLOTS);
  localparam logic [CW-1:0] LAST_CLI = CW'(CLIENTS - 1);

  place_ph_e       ph_q;
  logic [CW-1:0]   cli_q;
  logic [PW-1:0]   pos_q;
  logic [PW-1:0]   stride_q;
  logic [BW-1:0]   budget_q;

  logic [REQ_W-1:0] req_cur;
  logic             zero_req, grant_zero, skip_cli, walk_end, advance;

  assign req_cur    = req_i[int'(cli_q)*REQ_W +: REQ_W];
  assign zero_req   = (req_cur == '0);
  assign grant_zero = zero_req && active_i[cli_q] && (budget_q != '0);
  assign skip_cli   = zero_req && !grant_zero;
  assign walk_end   = (pos_q >= END_POS);
  assign advance    = ((ph_q == PH_PICK) && skip_cli) || ((ph_q == PH_WALK) && walk_end);

  assign raddr_o  = pos_q[IW-1:0];
  assign waddr_o  = pos_q[IW-1:0];
  assign wdata_o  = cli_q;
  assign we_o     = (ph_q == PH_WALK) && !walk_end && !occupied_i;
  assign finish_o = advance && (cli_q == LAST_CLI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_OFF;
      cli_q    <= '0;
      pos_q    <= '0;
      stride_q <= '0;
      budget_q <= '0;
    end else if (kick_i) begin
      ph_q     <= PH_PICK;
      cli_q    <= '0;
      pos_q    <= '0;
      budget_q <= budget_i;
    end else if (advance) begin
      if (cli_q == LAST_CLI) begin
        ph_q <= PH_OFF;
      end else begin
        ph_q  <= PH_PICK;
        cli_q <= cli_q + CW'(1);
      end
    end else if (ph_q == PH_PICK) begin
      stride_q <= PW'(stride_for(int'(req_cur), SLOTS));
      pos_q    <= '0;
      ph_q     <= PH_WALK;
      if (grant_zero) budget_q <= budget_q - BW'(1);
    end else if (ph_q == PH_WALK) begin
      if (occupied_i) pos_q <= pos_q + PW'(1);
      else            pos_q <= pos_q + stride_q;
    end
  end

  // R5: the zero-request budget never grows during a run
  p_budget_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_i |=> budget_q <= $past(budget_q));

  // R3: clients are visited in ascending order within a run
  p_client_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_OFF) && !kick_i |=> (ph_q == PH_OFF) || (cli_q >= $past(cli_q)));

  // R3: a write only happens inside the table
  p_write_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> pos_q < END_POS);

endmodule

// File: rtl/slotfill_engine.sv
module slotfill_engine
  import slotfill_pkg::*;
#(
  parameter int SLOTS   = 64,
  parameter int CLIENTS = 14,
  parameter int REQ_W   = 8,
  localparam int IW     = $clog2(SLOTS),
  localparam int CW     = $clog2(CLIENTS + 1),
  localparam int BW     = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [CLIENTS*REQ_W-1:0] req_cnt_i,
  input  logic [CLIENTS-1:0]       active_i,
  input  logic [BW-1:0]            budget_i,
  output logic                     busy_o,
  output logic                     wr_valid_o,
  output logic [IW-1:0]            wr_idx_o,
  output logic [CW-1:0]            wr_val_o,
  output logic                     done_o
);

  localparam logic [IW-1:0] LAST_SLOT = IW'(SLOTS - 1);

  sf_state_e                st_q;
  logic [CLIENTS*REQ_W-1:0] req_q;
  logic [CLIENTS-1:0]       act_q;
  logic [IW-1:0]            slot_q;
  logic [CW-1:0]            ptr_q;

  logic          kick;
  logic          p1_finish;
  logic          pl_we;
  logic [IW-1:0] pl_raddr, pl_waddr;
  logic [CW-1:0] pl_wdata;
  logic [IW-1:0] tb_raddr;
  logic [CW-1:0] tb_rdata;
  logic          tb_occ;
  logic [CW-1:0] rr_pick;
  logic          rr_found;
  logic [CW-1:0] fill_val;

  assign kick     = start_i && (st_q == ST_IDLE);
  assign busy_o   = (st_q != ST_IDLE);
  assign tb_raddr = (st_q == ST_P2) ? slot_q : pl_raddr;
  assign fill_val = tb_occ ? tb_rdata : rr_pick;

  sf_slot_table #(.SLOTS(SLOTS), .CW(CW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (kick),
    .we_i       (pl_we),
    .waddr_i    (pl_waddr),
    .wdata_i    (pl_wdata),
    .raddr_i    (tb_raddr),
    .rdata_o    (tb_rdata),
    .occupied_o (tb_occ)
  );

  sf_place_seq #(
    .SLOTS(SLOTS), .CLIENTS(CLIENTS), .REQ_W(REQ_W), .CW(CW), .BW(BW)
  ) u_place (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick_i     (kick),
    .req_i      (req_q),
    .active_i   (act_q),
    .budget_i   (budget_i),
    .occupied_i (tb_occ),
    .raddr_o    (pl_raddr),
    .we_o       (pl_we),
    .waddr_o    (pl_waddr),
    .wdata_o    (pl_wdata),
    .finish_o   (p1_finish)
  );

  sf_rr_pick #(.CLIENTS(CLIENTS), .CW(CW)) u_rr (
    .active_i (act_q),
    .ptr_i    (ptr_q),
    .pick_o   (rr_pick),
    .found_o  (rr_found)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      req_q      <= '0;
      act_q      <= '0;
      slot_q     <= '0;
      ptr_q      <= '0;
      wr_valid_o <= 1'b0;
      wr_idx_o   <= '0;
      wr_val_o   <= '0;
      done_o     <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      done_o     <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (kick) begin
            req_q  <= req_cnt_i;
            act_q  <= active_i;
            slot_q <= '0;
            ptr_q  <= '0;
            st_q   <= ST_P1;
          end
        end
        ST_P1: begin
          if (p1_finish) st_q <= ST_P2;
        end
        ST_P2: begin
          wr_valid_o <= 1'b1;
          wr_idx_o   <= slot_q;
          wr_val_o   <= fill_val;
          if (!tb_occ) ptr_q <= CW'(wrap_inc(int'(rr_pick), CLIENTS));
          slot_q <= slot_q + IW'(1);
          if (slot_q == LAST_SLOT) st_q <= ST_FIN;
        end
        ST_FIN: begin
          done_o <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: writes step through the slot indices one per cycle
  p_idx_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && (wr_idx_o != LAST_SLOT) |=> wr_valid_o && (wr_idx_o == $past(wr_idx_o) + IW'(1)));

  // R9: a burst of writes begins at slot 0
  p_first_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid_o) |-> wr_idx_o == '0);

  // R9: emitted owners are real client numbers
  p_val_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_val_o < CW'(CLIENTS));

  // R10: done follows the last write in the next cycle
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && (wr_idx_o == LAST_SLOT) |=> done_o && !wr_valid_o);

  // R10: done is a single-cycle pulse while idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o ##1 !done_o);

  // R7: a found pick names an active client
  p_rr_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_P2) && !tb_occ && rr_found |-> act_q[rr_pick]);

  // R2: a start during a run does not end it early
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_P1) && start_i |=> busy_o);

endmodule

// File: tb/sim_slotfill_engine.sv
module sim_slotfill_engine;

  localparam int NS = 64;
  localparam int NC = 14;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0;
  logic [NC*8-1:0] req_v = '0;
  logic [NC-1:0]  act_v = '0;
  logic [6:0]     bud_v = '0;
  logic           busy_o, wr_valid_o, done_o;
  logic [5:0]     wr_idx_o;
  logic [3:0]     wr_val_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  int m_req [NC];
  int m_act [NC];
  int m_bud;
  int exp_tab [NS];
  int cap [NS];
  int cap_n, idx_err, done_n, done_bad;
  logic prev_last;

  always #5 clk = ~clk;

  slotfill_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_cnt_i(req_v),
    .active_i(act_v), .budget_i(bud_v), .busy_o(busy_o),
    .wr_valid_o(wr_valid_o), .wr_idx_o(wr_idx_o), .wr_val_o(wr_val_o),
    .done_o(done_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        done_n++;
        if (!prev_last || busy_o) done_bad++;
      end
      if (wr_valid_o) begin
        if (int'(wr_idx_o) != cap_n) idx_err++;
        if (cap_n < NS) cap[cap_n] = int'(wr_val_o);
        cap_n++;
      end
      prev_last = wr_valid_o && (wr_idx_o == 6'd63);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic clear_cfg();
    for (int c = 0; c < NC; c++) begin m_req[c] = 0; m_act[c] = 0; end
    m_bud = 0;
    req_v = '0; act_v = '0; bud_v = '0;
  endtask

  task automatic set_cli(input int c, input int r, input int a);
    m_req[c] = r; m_act[c] = a;
    req_v[c*8 +: 8] = 8'(r);
    act_v[c] = a[0];
  endtask

  task automatic set_budget(input int b);
    m_bud = b; bud_v = 7'(b);
  endtask

  // Independent model of the fill rules
  task automatic build_model();
    int left, ptr;
    left = m_bud;
    for (int s = 0; s < NS; s++) exp_tab[s] = -1;
    for (int c = 0; c < NC; c++) begin
      int step, p, r;
      r = (m_req[c] > NS) ? NS : m_req[c];
      if (r == 0) begin
        if (m_act[c] == 0 || left <= 0) continue;
        left--;
        step = NS;
      end else step = NS / r;
      p = 0;
      while (p < NS) begin
        if (exp_tab[p] != -1) p = p + 1;
        else begin exp_tab[p] = c; p = p + step; end
      end
    end
    ptr = 0;
    for (int s = 0; s < NS; s++) begin
      if (exp_tab[s] == -1) begin
        int who;
        who = ptr;
        for (int k = 0; k < NC; k++) begin
          if (m_act[(ptr + k) % NC] != 0) begin who = (ptr + k) % NC; break; end
        end
        exp_tab[s] = who;
        ptr = (who + 1) % NC;
      end
    end
  endtask

  task automatic launch();
    build_model();
    cap_n = 0; idx_err = 0; done_n = 0; done_bad = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
  endtask

  task automatic finish_run(input string tag);
    int mism, first;
    for (int i = 0; i < 4000 && done_n == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check(cap_n == NS, "R9 write count", cap_n, NS);
    check(idx_err == 0, "R9 index order", idx_err, 0);
    check(done_n == 1 && done_bad == 0, "R10 done timing", done_n * 10 + done_bad, 10);
    mism = 0; first = -1;
    for (int s = 0; s < NS; s++) if (cap[s] != exp_tab[s]) begin
      mism++; if (first < 0) first = s;
    end
    check(mism == 0, tag, (first < 0) ? 0 : cap[first], (first < 0) ? 0 : exp_tab[first]);
  endtask

  task automatic t_reset();
    check(busy_o === 1'b0, "R1 busy at reset", int'(busy_o), 0);
    check(wr_valid_o === 1'b0, "R1 wr_valid at reset", int'(wr_valid_o), 0);
    check(done_o === 1'b0, "R1 done at reset", int'(done_o), 0);
  endtask

  task automatic t_empty();
    clear_cfg();
    launch(); finish_run("R8 empty table");
    check(cap[13] == 13, "R8 slot 13", cap[13], 13);
    check(cap[14] == 0, "R8 slot 14 wraps", cap[14], 0);
  endtask

  task automatic t_equal_stride();
    clear_cfg();
    set_cli(0, 4, 1); set_cli(1, 4, 1);
    launch(); finish_run("R3 equal strides");
    check(cap[16] == 0, "R3 slot 16", cap[16], 0);
    check(cap[17] == 1, "R3 slot 17 slid", cap[17], 1);
    check(cap[49] == 1, "R3 slot 49", cap[49], 1);
  endtask

  task automatic t_uneven();
    clear_cfg();
    set_cli(0, 3, 1); set_cli(1, 2, 1);
    launch(); finish_run("R3 uneven stride");
    check(cap[63] == 0, "R3 slot 63 stride end", cap[63], 0);
    check(cap[33] == 1, "R3 slot 33", cap[33], 1);
  endtask

  task automatic t_zero_grant();
    clear_cfg();
    set_cli(0, 32, 1); set_cli(2, 0, 1); set_cli(5, 0, 1); set_cli(9, 0, 1);
    set_budget(2);
    launch(); finish_run("R5 zero-request grant");
    check(cap[1] == 2, "R5 slot 1 grant", cap[1], 2);
    check(cap[3] == 5, "R5 slot 3 grant", cap[3], 5);
    check(cap[11] == 9, "R7 slot 11 rotation", cap[11], 9);
    set_budget(0);
    launch(); finish_run("R5 budget zero");
    check(cap[1] == 0, "R5 no grant without budget", cap[1], 0);
  endtask

  task automatic t_inactive();
    int hits;
    clear_cfg();
    set_cli(1, 0, 1); set_cli(4, 0, 1); set_budget(10);
    launch(); finish_run("R6 inactive skipped");
    hits = 0;
    for (int s = 0; s < NS; s++) if (cap[s] == 3) hits++;
    check(hits == 0, "R6 inactive owns nothing", hits, 0);
    check(cap[2] == 1 && cap[3] == 4, "R7 alternation", cap[2] * 16 + cap[3], 1 * 16 + 4);
  endtask

  task automatic t_clamp();
    int hits;
    clear_cfg();
    set_cli(7, 100, 1);
    launch(); finish_run("R4 oversize request");
    hits = 0;
    for (int s = 0; s < NS; s++) if (cap[s] == 7) hits++;
    check(hits == NS, "R4 all slots to client 7", hits, NS);
  endtask

  task automatic t_busy_start();
    clear_cfg();
    set_cli(0, 8, 1); set_cli(3, 0, 1); set_budget(1);
    launch();
    repeat (30) @(negedge clk);
    set_cli(0, 0, 0); set_cli(6, 64, 1);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    finish_run("R2 start ignored while busy");
    repeat (10) @(negedge clk);
    check(busy_o === 1'b0 && cap_n == NS, "R2 no second run", cap_n, NS);
  endtask

  initial begin
    prev_last = 1'b0;
    cap_n = 0; idx_err = 0; done_n = 0; done_bad = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_empty();
    t_equal_stride();
    t_uneven();
    t_zero_grant();
    t_inactive();
    t_clamp();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule